// File: doc/BRIEF.md
# Fixed-Point Twin Lasso Depth Solver

This block rebuilds the depth values of one small pixel block from compressive sensor data. It receives two sets of compressive measurements taken through one fixed 0/1 selection matrix: one set for the depth-weighted photon sum and one for the photon intensity. For each set it runs a fixed number of proximal gradient iterations. Each iteration applies an ℓ1 shrinkage to the DCT coefficients of the current estimate. When both estimates are ready, it divides them pixel by pixel and streams out the depth vector.

Both problems run one after the other on a single multiply-accumulate datapath. The matrix products are sequenced one term per cycle. A control module walks the loop nest and drives the datapath through a small strobe record. Each block is handled on its own: nothing from one block carries into the next. This lets a larger engine place several copies side by side, each fed one block at a time.

Top module: `twin_lasso_depth`

## Requirements
- R1: Every value is a 22-bit two's-complement number with 12 fraction bits. Every stored intermediate result is rounded half-up to 12 fraction bits (add 2048, then shift right arithmetically by 12). A value outside [-2097152, 2097151] saturates to the nearest bound instead of wrapping.
- R2: Input words arrive on inData in this order: step size t, weight λ, NMEAS depth-sum measurements, then NMEAS intensity measurements. A word is taken on a clock edge where inValid and inReady are both high. inReady is high only while a block is being collected. It is low from the edge that takes the last word until the edge that hands over the last output word, and high again straight after that edge.
- R3: The iteration count is sampled from iterCnt together with the first word (t) of a block. Changes to iterCnt later in the block have no effect. Both estimates start from all zeros. A count of zero leaves both estimates at zero.
- R4: Each iteration, for measurement row i and pixel j, with the matrix entry A[i][j] = 1 when (7i + 3j + i·j) mod 5 < 2 and 0 otherwise, computes: r_i = sat(Σ_j A[i][j]·x_j − y_i), g_j = sat(Σ_i A[i][j]·r_i), z_j = sat(x_j − rnd(t·g_j)).
- R5: The transform coefficient is C[k][j] = round-to-nearest(4096·s_k·cos(π(2j+1)k/(2·NPIX))), where s_0 = sqrt(1/NPIX) and s_k = sqrt(2/NPIX) otherwise. Each iteration computes c_k = sat(rnd(Σ_j C[k][j]·z_j)). It then shrinks c_k toward zero by θ = max(0, sat(rnd(t·λ))): c−θ above θ, c+θ below −θ, and 0 in between. The new estimate is x_j = sat(rnd(Σ_k C[k][j]·c_k)).
- R6: The first problem uses the depth-sum measurements and the second the intensity measurements, with the same t, λ and count. The depth of pixel j is q_j·4096 / p_j truncated toward zero and saturated, where q is the depth-sum result and p the intensity result.
- R7: A pixel whose intensity result is zero or negative outputs depth 0. outBad is then high on every output word of that block. outBad is low for a block with no such pixel.
- R8: The block emits NPIX words in pixel order, with outLast high only on the last one. While outValid is high and outReady is low, outData and outLast hold their values.
- R9: outValid rises exactly 3 + 2·I·(2·NMEAS·NPIX + 2·NPIX²) + 35·NPIX clock edges after the edge that takes the last input word, where I is the sampled iteration count.
- R10: The results of a block depend only on that block's words. Feeding the same words again gives the same output, whatever came in between and however the handshakes are paced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word present |
| inReady | output | 1 | Block collecting input words |
| inData | input | 22 | Input word, Q10.12 |
| iterCnt | input | 8 | Iteration count, sampled with the first word |
| outValid | output | 1 | Depth word present |
| outReady | input | 1 | Downstream takes the depth word |
| outData | output | 22 | Depth word, Q10.12 |
| outLast | output | 1 | Marks the final pixel of the block |
| outBad | output | 1 | Block contained a pixel with non-positive intensity |

## Verification
An input word counts as taken at the edge after it is driven, and the solver's output timing is then fixed. The first depth word is due after 3 edges of bookkeeping, 768 edges per iteration per problem at the default size, and 35 edges of division per pixel. The bench counts edges from the edge that takes the last word and expects outValid exactly at that count. Output words are compared at every falling edge while outValid is high, against a behavioural integer model of the requirements. The expected index advances only after a falling edge at which both outValid and outReady were high, so each word is checked again on every cycle it is held back.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int W    = 22;   // word width
  localparam int FB   = 12;   // fraction bits
  localparam int AW   = 48;   // accumulator width
  localparam int CW   = 16;   // transform coefficient width
  localparam int IDXW = 8;    // loop index width

  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FB - 1);
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (W - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (W - 1));

  typedef enum logic [3:0] {
    OP_IDLE, OP_LOAD, OP_CLRX, OP_RES, OP_GRAD, OP_FWD, OP_INV, OP_SAVEQ, OP_DIVLD, OP_DIV
  } op_e;

  typedef struct packed {
    op_e             op;
    logic            first;  // clear accumulator before this term
    logic            last;   // write the finished result
    logic            prob;   // 0: depth-sum problem, 1: intensity problem
    logic [IDXW-1:0] row;
    logic [IDXW-1:0] col;
  } strobe_t;

  function automatic logic signed [W-1:0] satW(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] c;
    c = (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
    return c[W-1:0];
  endfunction

  function automatic logic signed [AW-1:0] rndQ(input logic signed [AW-1:0] v);
    return (v + HALF) >>> FB;
  endfunction

  function automatic logic signed [W-1:0] softTh(input logic signed [W-1:0] c,
                                                 input logic signed [W-1:0] thr);
    if (c > thr) return c - thr;
    else if (c < -thr) return c + thr;
    else return '0;
  endfunction

  function automatic int dctCoef(input int k, input int j, input int n);
    real a, v;
    a = (k == 0) ? $sqrt(1.0 / real'(n)) : $sqrt(2.0 / real'(n));
    v = a * $cos(3.14159265358979 * real'((2 * j + 1) * k) / (2.0 * real'(n))) * 4096.0;
    return $rtoi($floor(v + 0.5));
  endfunction

  function automatic logic measBit(input int i, input int j);
    return ((i * 7 + j * 3 + i * j) % 5) < 2;
  endfunction
endpackage

// File: rtl/tl_ctrl.sv
module tl_ctrl
  import tl_pkg::*;
#(
  parameter int NPIX  = 16,
  parameter int NMEAS = 8,
  parameter int ITW   = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           outReady,
  input  logic [ITW-1:0] iterCnt,
  output logic           inReady,
  output logic           outValid,
  output logic           outLast,
  output strobe_t        st
);
  localparam logic [IDXW-1:0] NP       = IDXW'(NPIX);
  localparam logic [IDXW-1:0] NM       = IDXW'(NMEAS);
  localparam logic [IDXW-1:0] DSTEPS   = IDXW'(W + FB);
  localparam logic [IDXW-1:0] LOADLAST = IDXW'(1 + 2 * NMEAS);
  localparam logic [IDXW-1:0] YQBASE   = IDXW'(2);
  localparam logic [IDXW-1:0] YIBASE   = IDXW'(2 + NMEAS);

  typedef enum logic [3:0] {
    S_LOAD, S_CLR, S_RES, S_GRAD, S_FWD, S_INV, S_SAVE, S_DIVL, S_DIV, S_OUT
  } state_e;

  state_e state;
  logic [IDXW-1:0] row, col, loadIdx, rowLim, colLim;
  logic [ITW-1:0]  iterReg, iterIdx;
  logic            prob, rowEnd, colEnd, lastIter;

  always_comb begin
    rowLim = NP;
    colLim = NP;
    case (state)
      S_RES:  rowLim = NM;
      S_GRAD: colLim = NM;
      S_DIV:  colLim = DSTEPS;
      default: ;
    endcase
  end

  assign colEnd   = (col == colLim - 1'b1);
  assign rowEnd   = (row == rowLim - 1'b1);
  assign lastIter = (iterIdx == iterReg - 1'b1);
  assign inReady  = (state == S_LOAD);
  assign outValid = (state == S_OUT);
  assign outLast  = outValid && rowEnd;

  always_comb begin
    st.op    = OP_IDLE;
    st.first = (col == '0);
    st.last  = colEnd;
    st.prob  = prob;
    st.row   = row;
    st.col   = col;
    case (state)
      S_LOAD: begin
        st.op = inValid ? OP_LOAD : OP_IDLE;
        if (loadIdx < YQBASE) begin
          st.col = loadIdx;
          st.row = '0;
        end else if (loadIdx < YIBASE) begin
          st.col  = YQBASE;
          st.row  = loadIdx - YQBASE;
          st.prob = 1'b0;
        end else begin
          st.col  = YQBASE;
          st.row  = loadIdx - YIBASE;
          st.prob = 1'b1;
        end
      end
      S_CLR:  st.op = OP_CLRX;
      S_RES:  st.op = OP_RES;
      S_GRAD: st.op = OP_GRAD;
      S_FWD:  st.op = OP_FWD;
      S_INV:  st.op = OP_INV;
      S_SAVE: st.op = OP_SAVEQ;
      S_DIVL: st.op = OP_DIVLD;
      S_DIV:  st.op = OP_DIV;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_LOAD;
      row     <= '0;
      col     <= '0;
      loadIdx <= '0;
      iterReg <= '0;
      iterIdx <= '0;
      prob    <= 1'b0;
    end else begin
      case (state)
        S_LOAD: if (inValid) begin
          if (loadIdx == '0) iterReg <= iterCnt;
          if (loadIdx == LOADLAST) begin
            loadIdx <= '0;
            prob    <= 1'b0;
            state   <= S_CLR;
          end else begin
            loadIdx <= loadIdx + 1'b1;
          end
        end
        S_CLR: begin
          row     <= '0;
          col     <= '0;
          iterIdx <= '0;
          if (iterReg == '0) state <= prob ? S_DIVL : S_SAVE;
          else state <= S_RES;
        end
        S_RES, S_GRAD, S_FWD, S_INV: begin
          if (!colEnd) begin
            col <= col + 1'b1;
          end else begin
            col <= '0;
            if (!rowEnd) begin
              row <= row + 1'b1;
            end else begin
              row <= '0;
              case (state)
                S_RES:  state <= S_GRAD;
                S_GRAD: state <= S_FWD;
                S_FWD:  state <= S_INV;
                default: begin
                  if (lastIter) begin
                    state <= prob ? S_DIVL : S_SAVE;
                  end else begin
                    iterIdx <= iterIdx + 1'b1;
                    state   <= S_RES;
                  end
                end
              endcase
            end
          end
        end
        S_SAVE: begin
          prob  <= 1'b1;
          state <= S_CLR;
        end
        S_DIVL: begin
          col   <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          if (!colEnd) begin
            col <= col + 1'b1;
          end else begin
            col <= '0;
            if (rowEnd) begin
              row   <= '0;
              state <= S_OUT;
            end else begin
              row   <= row + 1'b1;
              state <= S_DIVL;
            end
          end
        end
        S_OUT: if (outReady) begin
          if (rowEnd) begin
            row   <= '0;
            state <= S_LOAD;
          end else begin
            row <= row + 1'b1;
          end
        end
        default: state <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/tl_datapath.sv
module tl_datapath
  import tl_pkg::*;
#(
  parameter int NPIX  = 16,
  parameter int NMEAS = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       st,
  input  logic [W-1:0]  inData,
  output logic [W-1:0]  outData,
  output logic          outBad
);
  localparam int PIW = $clog2(NPIX);
  localparam int MIW = $clog2(NMEAS);
  localparam int DNW = W + FB;

  logic signed [CW-1:0] coefTab [NPIX][NPIX];
  logic                 aTab    [NMEAS][NPIX];

  for (genvar k = 0; k < NPIX; k++) begin : g_coefRow
    for (genvar j = 0; j < NPIX; j++) begin : g_coefCol
      assign coefTab[k][j] = CW'(dctCoef(k, j, NPIX));
    end
  end
  for (genvar i = 0; i < NMEAS; i++) begin : g_measRow
    for (genvar j = 0; j < NPIX; j++) begin : g_measCol
      assign aTab[i][j] = measBit(i, j);
    end
  end

  logic signed [W-1:0] yBuf  [2][NMEAS];
  logic signed [W-1:0] rBuf  [NMEAS];
  logic signed [W-1:0] xBuf  [NPIX];
  logic signed [W-1:0] zBuf  [NPIX];
  logic signed [W-1:0] cBuf  [NPIX];
  logic signed [W-1:0] qBuf  [NPIX];
  logic signed [W-1:0] depBuf[NPIX];

  logic signed [W-1:0]  tReg, thrReg, thrNew, qv;
  logic signed [AW-1:0] acc, accNext, term, quoS;
  logic [W-1:0]         divDen, divRem, qMag;
  logic [DNW-1:0]       divNum, divQuo, quoNext;
  logic [W:0]           remSh, remNext;
  logic                 divNeg, divSkip, badReg, geq;
  logic signed [W-1:0]  divRes;

  logic [PIW-1:0] pr, pc;
  logic [MIW-1:0] mr, mc;
  assign pr = st.row[PIW-1:0];
  assign pc = st.col[PIW-1:0];
  assign mr = st.row[MIW-1:0];
  assign mc = st.col[MIW-1:0];

  // one product or selected term per cycle
  always_comb begin
    term = '0;
    case (st.op)
      OP_RES:  if (aTab[mr][pc]) term = AW'(xBuf[pc]);
      OP_GRAD: if (aTab[mc][pr]) term = AW'(rBuf[mc]);
      OP_FWD:  term = AW'(coefTab[pr][pc]) * AW'(zBuf[pc]);
      OP_INV:  term = AW'(coefTab[pc][pr]) * AW'(cBuf[pc]);
      default: ;
    endcase
    accNext = (st.first ? '0 : acc) + term;
  end

  // restoring divider step and result
  always_comb begin
    qv      = qBuf[pr];
    qMag    = qv[W-1] ? W'(-qv) : W'(qv);
    thrNew  = satW(rndQ(AW'(tReg) * AW'($signed(inData))));
    remSh   = {divRem, divNum[DNW-1]};
    geq     = (remSh >= {1'b0, divDen});
    remNext = geq ? (remSh - {1'b0, divDen}) : remSh;
    quoNext = {divQuo[DNW-2:0], geq};
    quoS    = $signed({{(AW - DNW){1'b0}}, quoNext});
    divRes  = divSkip ? '0 : satW(divNeg ? -quoS : quoS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      tReg    <= '0;
      thrReg  <= '0;
      divDen  <= '0;
      divRem  <= '0;
      divNum  <= '0;
      divQuo  <= '0;
      divNeg  <= 1'b0;
      divSkip <= 1'b0;
      badReg  <= 1'b0;
    end else begin
      acc <= accNext;
      case (st.op)
        OP_LOAD: begin
          if (st.col == IDXW'(0)) tReg <= $signed(inData);
          if (st.col == IDXW'(1)) thrReg <= thrNew[W-1] ? '0 : thrNew;
        end
        OP_CLRX: if (!st.prob) badReg <= 1'b0;
        OP_DIVLD: begin
          divDen  <= xBuf[pr][W-1:0];
          divNeg  <= qv[W-1];
          divSkip <= (xBuf[pr] <= 0);
          divNum  <= {qMag, {FB{1'b0}}};
          divRem  <= '0;
          divQuo  <= '0;
          if (xBuf[pr] <= 0) badReg <= 1'b1;
        end
        OP_DIV: begin
          divRem <= remNext[W-1:0];
          divNum <= divNum << 1;
          divQuo <= quoNext;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    case (st.op)
      OP_LOAD:  if (st.col == IDXW'(2)) yBuf[st.prob][mr] <= $signed(inData);
      OP_CLRX:  for (int j = 0; j < NPIX; j++) xBuf[j] <= '0;
      OP_RES:   if (st.last) rBuf[mr] <= satW(accNext - AW'(yBuf[st.prob][mr]));
      OP_GRAD:  if (st.last) zBuf[pr] <= satW(AW'(xBuf[pr]) - rndQ(AW'(tReg) * AW'(satW(accNext))));
      OP_FWD:   if (st.last) cBuf[pr] <= softTh(satW(rndQ(accNext)), thrReg);
      OP_INV:   if (st.last) xBuf[pr] <= satW(rndQ(accNext));
      OP_SAVEQ: for (int j = 0; j < NPIX; j++) qBuf[j] <= xBuf[j];
      OP_DIV:   if (st.last) depBuf[pr] <= divRes;
      default: ;
    endcase
  end

  assign outData = depBuf[pr];
  assign outBad  = badReg;
endmodule

// File: rtl/twin_lasso_depth.sv
module twin_lasso_depth
  import tl_pkg::*;
#(
  parameter int NPIX  = 16,
  parameter int NMEAS = 8,
  parameter int ITW   = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output logic           inReady,
  input  logic [W-1:0]   inData,
  input  logic [ITW-1:0] iterCnt,
  output logic           outValid,
  input  logic           outReady,
  output logic [W-1:0]   outData,
  output logic           outLast,
  output logic           outBad
);
  strobe_t st;

  tl_ctrl #(.NPIX(NPIX), .NMEAS(NMEAS), .ITW(ITW)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .iterCnt(iterCnt), .inReady(inReady), .outValid(outValid),
    .outLast(outLast), .st(st)
  );

  tl_datapath #(.NPIX(NPIX), .NMEAS(NMEAS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData),
    .outData(outData), .outBad(outBad)
  );
endmodule

// File: rtl/twin_lasso_depth_chk.sv
module twin_lasso_depth_chk
  import tl_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         inReady,
  input logic         outValid,
  input logic         outReady,
  input logic [W-1:0] outData,
  input logic         outLast,
  input logic         outBad
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast)); // R8

  AST_LAST_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R8

  AST_NO_INPUT_WHILE_OUT: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid); // R2

  AST_RESUME_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast |=> inReady); // R2

  AST_BAD_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    outValid && $past(outValid) |-> $stable(outBad)); // R7
endmodule

bind twin_lasso_depth twin_lasso_depth_chk u_chk (.*);

// File: tb/twin_lasso_depth_test.sv
`timescale 1ns/1ps
module twin_lasso_depth_test;
  localparam int NPIX = 16, NMEAS = 8, W = 22, ITW = 8;
  localparam longint MAXV = 2097151, MINV = -2097152;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, inValid = 1'b0, outReady = 1'b0;
  logic [W-1:0] inData = '0;
  logic [ITW-1:0] iterCnt = '0;
  logic inReady, outValid, outLast, outBad;
  logic [W-1:0] outData;

  twin_lasso_depth uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .iterCnt(iterCnt), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .outBad(outBad)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  longint yv [2][NMEAS];
  longint xs [2][NPIX];
  longint expDep [NPIX];
  bit expBad;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v);
    return (v > MAXV) ? MAXV : ((v < MINV) ? MINV : v);
  endfunction
  function automatic longint rnd(input longint v);
    return (v + 2048) >>> 12;
  endfunction
  function automatic longint aM(input int i, input int j);
    return (((i * 7 + j * 3 + i * j) % 5) < 2) ? 1 : 0;
  endfunction
  function automatic longint cM(input int k, input int j);
    real s;
    s = (k == 0) ? $sqrt(1.0 / NPIX) : $sqrt(2.0 / NPIX);
    return longint'($rtoi($floor(s * $cos(3.14159265358979 * real'((2 * j + 1) * k)
                                  / (2.0 * NPIX)) * 4096.0 + 0.5)));
  endfunction

  // behavioural model of the requirements
  task automatic model(input longint t, input longint lam, input int it);
    longint thr, r[NMEAS], z[NPIX], c[NPIX], s, q, p, quo;
    thr = sat(rnd(t * lam));
    if (thr < 0) thr = 0;
    for (int pb = 0; pb < 2; pb++) begin
      for (int j = 0; j < NPIX; j++) xs[pb][j] = 0;
      for (int n = 0; n < it; n++) begin
        for (int i = 0; i < NMEAS; i++) begin
          s = 0;
          for (int j = 0; j < NPIX; j++) s += aM(i, j) * xs[pb][j];
          r[i] = sat(s - yv[pb][i]);
        end
        for (int j = 0; j < NPIX; j++) begin
          s = 0;
          for (int i = 0; i < NMEAS; i++) s += aM(i, j) * r[i];
          z[j] = sat(xs[pb][j] - rnd(t * sat(s)));
        end
        for (int k = 0; k < NPIX; k++) begin
          s = 0;
          for (int j = 0; j < NPIX; j++) s += cM(k, j) * z[j];
          s = sat(rnd(s));
          c[k] = (s > thr) ? s - thr : ((s < -thr) ? s + thr : 0);
        end
        for (int j = 0; j < NPIX; j++) begin
          s = 0;
          for (int k = 0; k < NPIX; k++) s += cM(k, j) * c[k];
          xs[pb][j] = sat(rnd(s));
        end
      end
    end
    expBad = 1'b0;
    for (int j = 0; j < NPIX; j++) begin
      q = xs[0][j];
      p = xs[1][j];
      if (p <= 0) begin
        expDep[j] = 0;
        expBad = 1'b1;
      end else begin
        quo = ((q < 0) ? -q : q) * 4096 / p;
        expDep[j] = sat((q < 0) ? -quo : quo);
      end
    end
  endtask

  task automatic runBlock(input longint t, input longint lam, input int it, input bit gaps,
                          input bit bp, input int altIter, input string tag);
    longint words [2 + 2 * NMEAS];
    int cnt, idx, lat;
    bit busyOk;
    words[0] = t;
    words[1] = lam;
    for (int i = 0; i < NMEAS; i++) begin
      words[2 + i] = yv[0][i];
      words[2 + NMEAS + i] = yv[1][i];
    end
    model(t, lam, it);
    lat = 3 + 2 * it * (2 * NMEAS * NPIX + 2 * NPIX * NPIX) + 35 * NPIX;
    for (int w = 0; w < 2 + 2 * NMEAS; w++) begin
      @(negedge clk);
      if (gaps && (w % 3 == 1)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      inValid = 1'b1;
      inData  = W'(words[w]);
      iterCnt = (w == 0) ? ITW'(it) : ITW'(altIter);
    end
    @(posedge clk);
    cnt = 0;
    busyOk = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    while (!outValid && cnt < lat + 10) begin
      if (inReady) busyOk = 1'b0;
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    check(busyOk, {"R2 inReady low while solving ", tag}, busyOk, 1);
    check(cnt == lat, {"R9 latency to first word ", tag}, cnt, lat);
    idx = 0;
    while (idx < NPIX && outValid) begin
      outReady = bp ? ((cyc % 3) != 2) : 1'b1;
      check(longint'($signed(outData)) == expDep[idx], {"R6 depth word ", tag},
            longint'($signed(outData)), expDep[idx]);
      check(outLast == (idx == NPIX - 1), {"R8 last marker ", tag}, outLast, idx == NPIX - 1);
      check(outBad == expBad, {"R7 block flag ", tag}, outBad, expBad);
      if (outReady) idx++;
      @(negedge clk);
    end
    outReady = 1'b0;
    check(idx == NPIX, {"R8 word count ", tag}, idx, NPIX);
    check(inReady == 1'b1 && outValid == 1'b0, {"R2 ready for next block ", tag}, inReady, 1);
  endtask

  always @(posedge clk) cyc++;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R2 reset ready", inReady, 1);
    check(outValid == 1'b0, "R8 reset no output", outValid, 0);

    // typical block: R4 R5 R6
    for (int i = 0; i < NMEAS; i++) begin
      yv[1][i] = longint'((6 + i % 3) * 4096 + i * 300);
      yv[0][i] = yv[1][i] * 3 + longint'(i * 1000);
    end
    runBlock(164, 205, 6, 1'b0, 1'b0, 0, "R4 R5 typical");

    // zero iterations: R3 R7
    runBlock(164, 205, 0, 1'b0, 1'b0, 0, "R3 zero count");

    // negative intensity measurements: R7
    for (int i = 0; i < NMEAS; i++) begin
      yv[1][i] = -longint'((2 + i) * 4096);
      yv[0][i] = longint'((i + 1) * 2048);
    end
    runBlock(164, 205, 3, 1'b0, 1'b1, 0, "R7 negative intensity");

    // saturation: R1
    for (int i = 0; i < NMEAS; i++) begin
      yv[0][i] = MAXV;
      yv[1][i] = (i % 2 == 0) ? MAXV : MINV;
    end
    runBlock(4096, 4096, 2, 1'b0, 1'b0, 0, "R1 saturation");

    // non-positive weight clamps threshold to zero: R5
    for (int i = 0; i < NMEAS; i++) begin
      yv[1][i] = longint'((6 + i % 3) * 4096 + i * 300);
      yv[0][i] = yv[1][i] * 3 + longint'(i * 1000);
    end
    runBlock(164, -4096, 2, 1'b0, 1'b0, 0, "R5 clamped threshold");

    // same block again with paced handshakes and a late count change: R10 R3
    runBlock(164, 205, 6, 1'b1, 1'b1, 1, "R10 repeat with pacing");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule